// File: doc/BRIEF.md
# MII to RMII Datapath Bridge

This block joins a MAC that speaks a 4-bit media-independent interface to a PHY that speaks the reduced 2-bit interface. Both sides run from one 50 MHz reference clock. The slower MAC nibble timing is not a separate clock. It is a one-cycle strobe derived from the reference clock. On transmit, the MAC places a nibble and its enable on the inputs during the strobe cycle. The bridge then sends that nibble to the PHY as two dibits, low pair first. On receive, the bridge samples the PHY dibits once per dibit slot. It finds the nibble boundary from the preamble and delivers nibbles with valid, carrier and error flags, each time with a one-cycle receive strobe.

A speed request chooses 100 Mbps or 10 Mbps. At 100 Mbps a dibit slot is one reference cycle. At 10 Mbps a dibit slot is ten reference cycles, so each transmitted dibit is held for ten cycles and each received dibit is sampled once in its ten-cycle window. A new speed is adopted only at a transmit nibble boundary, and only after both directions have been quiet for a whole nibble. Because of this, the MAC never sees a truncated nibble period.

Top module: `mii_rmii_bridge`

## Requirements
- R1: Consecutive transmit strobes (`mii_tx_stb`) are exactly 2 reference cycles apart at 100 Mbps and exactly 20 at 10 Mbps. Across a speed change, no other spacing ever occurs.
- R2: The nibble and enable present during a strobe cycle appear on `rmii_txd`/`rmii_tx_en` from the next cycle, with bits [1:0] first. Bits [3:2] follow one dibit slot later. The enable accompanies both dibits.
- R3: At 10 Mbps each transmit dibit and its enable stay unchanged for 10 consecutive reference cycles.
- R4: Receive dibits are sampled once per dibit slot: every cycle at 100 Mbps, and once in each 10-cycle window at 10 Mbps. A delivered nibble carries the first-received dibit in bits [1:0] and the second in bits [3:2].
- R5: Outside a frame, a nibble boundary is fixed by the first dibit equal to 01 that is received while `rmii_crs_dv` is high. A 01 received with `rmii_crs_dv` low, and dibits received before the alignment point, yield no valid nibble.
- R6: Inside a frame, `mii_rx_dv` stays high for every nibble in which `rmii_crs_dv` was high on at least one of its two dibits. The first nibble with `rmii_crs_dv` low on both dibits is delivered with `mii_rx_dv` low and ends the frame.
- R7: `mii_rx_er` is high for a delivered valid nibble exactly when `rmii_rx_er` was high on either of its dibits.
- R8: `mii_crs` equals `rmii_crs_dv` as sampled in the latest dibit slot.
- R9: `speed_100` changes only on a transmit strobe cycle. That cycle must have the MAC enable low, and the whole preceding nibble period must have had no transmit enable on the PHY side, no receive frame and no `rmii_crs_dv`. A request made during traffic is deferred until then.
- R10: While reset is asserted and right after it, `rmii_txd`, `rmii_tx_en`, `mii_rxd`, `mii_rx_dv`, `mii_rx_er` and `mii_crs` are 0, and `speed_100` takes the value of parameter `RESET_FAST` (default 1).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 50 MHz reference clock for both directions |
| rst_n | input | 1 | Asynchronous active-low reset |
| speed_100_req | input | 1 | Requested speed: 1 = 100 Mbps, 0 = 10 Mbps |
| speed_100 | output | 1 | Speed currently in effect |
| mii_tx_stb | output | 1 | Transmit nibble strobe; MAC nibble is captured in this cycle |
| mii_txd | input | 4 | Transmit nibble from the MAC |
| mii_tx_en | input | 1 | Transmit enable from the MAC |
| rmii_txd | output | 2 | Transmit dibit to the PHY |
| rmii_tx_en | output | 1 | Transmit enable to the PHY |
| rmii_rxd | input | 2 | Receive dibit from the PHY |
| rmii_crs_dv | input | 1 | Combined carrier/data-valid from the PHY |
| rmii_rx_er | input | 1 | Receive error from the PHY |
| mii_rx_stb | output | 1 | One-cycle pulse when receive outputs update |
| mii_rxd | output | 4 | Receive nibble to the MAC |
| mii_rx_dv | output | 1 | Receive data valid to the MAC |
| mii_rx_er | output | 1 | Receive error to the MAC |
| mii_crs | output | 1 | Carrier sense to the MAC |

## Verification
The speed switch and the transmit nibble capture share the same strobe cycle. The risky case is a speed request that is pending when the MAC raises its enable on that strobe. The bench provokes this by changing the request right after the first nibble of a frame has been accepted. It then judges three things: the speed must hold through the last dibit, every strobe spacing over the whole run must be exactly 2 or 20 cycles, and every dibit of the frame must arrive intact at the original speed. A second pairing is the end of a receive frame with alternating `rmii_crs_dv`. The bench checks that valid stays up through the toggling nibbles and drops only on the first fully-low nibble.

// File: rtl/mii_rmii_pkg.sv
package mii_rmii_pkg;

  // reference cycles per dibit slot in slow mode
  localparam int SLOW_DIV_DEF = 10;

  // reference cycles in one dibit slot for a given speed
  function automatic int slot_cycles(input logic fast, input int slow_div);
    return fast ? 1 : slow_div;
  endfunction

  // assemble a nibble from the first and second received dibits
  function automatic logic [3:0] join_dibits(input logic [1:0] first,
                                             input logic [1:0] second);
    return {second, first};
  endfunction

  // preamble dibit that marks a nibble boundary
  localparam logic [1:0] ALIGN_DIBIT = 2'b01;

endpackage

// File: rtl/rmii_slot_timer.sv
module rmii_slot_timer #(
  parameter int SLOW_DIV = mii_rmii_pkg::SLOW_DIV_DEF
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fast,
  input  logic restart,
  output logic dibit_tick
);
  localparam int CNT_W = (SLOW_DIV > 1) ? $clog2(SLOW_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(SLOW_DIV - 1);

  logic [CNT_W-1:0] cnt;

  assign dibit_tick = fast ? 1'b1 : (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt <= '0;
    else if (restart || dibit_tick || fast) cnt <= '0;
    else                               cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/mii_tx_serializer.sv
module mii_tx_serializer (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dibit_tick,
  input  logic [3:0] mii_txd,
  input  logic       mii_tx_en,
  output logic       nibble_stb,
  output logic [1:0] rmii_txd,
  output logic       rmii_tx_en
);
  logic       second_half;
  logic [1:0] upper_q;
  logic       en_q;

  assign nibble_stb = dibit_tick && !second_half;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      second_half <= 1'b0;
      upper_q     <= '0;
      en_q        <= 1'b0;
      rmii_txd    <= '0;
      rmii_tx_en  <= 1'b0;
    end else if (dibit_tick) begin
      second_half <= !second_half;
      if (!second_half) begin
        rmii_txd   <= mii_txd[1:0];
        rmii_tx_en <= mii_tx_en;
        upper_q    <= mii_txd[3:2];
        en_q       <= mii_tx_en;
      end else begin
        rmii_txd   <= upper_q;
        rmii_tx_en <= en_q;
      end
    end
  end
endmodule

// File: rtl/rmii_rx_gatherer.sv
module rmii_rx_gatherer
  import mii_rmii_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       dibit_tick,
  input  logic [1:0] rmii_rxd,
  input  logic       rmii_crs_dv,
  input  logic       rmii_rx_er,
  output logic       in_frame,
  output logic       out_stb,
  output logic [3:0] mii_rxd,
  output logic       mii_rx_dv,
  output logic       mii_rx_er,
  output logic       mii_crs
);
  logic       second_half;
  logic [1:0] first_q;
  logic       crs_first_q;
  logic       er_first_q;
  logic       start_hit;
  logic       crs_any;

  assign start_hit = rmii_crs_dv && (rmii_rxd == ALIGN_DIBIT);
  assign crs_any   = rmii_crs_dv || crs_first_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      second_half <= 1'b0;
      first_q     <= '0;
      crs_first_q <= 1'b0;
      er_first_q  <= 1'b0;
      in_frame    <= 1'b0;
      out_stb     <= 1'b0;
      mii_rxd     <= '0;
      mii_rx_dv   <= 1'b0;
      mii_rx_er   <= 1'b0;
      mii_crs     <= 1'b0;
    end else begin
      out_stb <= 1'b0;
      if (dibit_tick) begin
        mii_crs <= rmii_crs_dv;
        if (!in_frame) begin
          if (start_hit) begin
            in_frame    <= 1'b1;
            second_half <= 1'b1;
            first_q     <= rmii_rxd;
            crs_first_q <= rmii_crs_dv;
            er_first_q  <= rmii_rx_er;
          end else begin
            second_half <= !second_half;
            if (second_half) begin
              out_stb   <= 1'b1;
              mii_rxd   <= '0;
              mii_rx_dv <= 1'b0;
              mii_rx_er <= 1'b0;
            end
          end
        end else if (!second_half) begin
          second_half <= 1'b1;
          first_q     <= rmii_rxd;
          crs_first_q <= rmii_crs_dv;
          er_first_q  <= rmii_rx_er;
        end else begin
          second_half <= 1'b0;
          out_stb     <= 1'b1;
          mii_rx_dv   <= crs_any;
          mii_rx_er   <= crs_any && (rmii_rx_er || er_first_q);
          mii_rxd     <= crs_any ? join_dibits(first_q, rmii_rxd) : 4'h0;
          if (!crs_any) in_frame <= 1'b0;
        end
      end
    end
  end
endmodule

// File: rtl/rmii_speed_ctrl.sv
module rmii_speed_ctrl #(
  parameter bit RESET_FAST = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic speed_req,
  input  logic boundary,
  input  logic busy_now,
  input  logic mac_tx_en,
  output logic speed_fast,
  output logic switch_now
);
  logic quiet_q;

  assign switch_now = boundary && quiet_q && !busy_now && !mac_tx_en &&
                      (speed_req != speed_fast);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      quiet_q    <= 1'b0;
      speed_fast <= RESET_FAST;
    end else begin
      if (boundary) quiet_q <= 1'b1;
      else          quiet_q <= quiet_q && !busy_now;
      if (switch_now) speed_fast <= speed_req;
    end
  end
endmodule

// File: rtl/mii_rmii_bridge.sv
module mii_rmii_bridge #(
  parameter int SLOW_DIV   = mii_rmii_pkg::SLOW_DIV_DEF,
  parameter bit RESET_FAST = 1'b1
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       speed_100_req,
  output logic       speed_100,
  output logic       mii_tx_stb,
  input  logic [3:0] mii_txd,
  input  logic       mii_tx_en,
  output logic [1:0] rmii_txd,
  output logic       rmii_tx_en,
  input  logic [1:0] rmii_rxd,
  input  logic       rmii_crs_dv,
  input  logic       rmii_rx_er,
  output logic       mii_rx_stb,
  output logic [3:0] mii_rxd,
  output logic       mii_rx_dv,
  output logic       mii_rx_er,
  output logic       mii_crs
);
  // internal events, named for the checker
  logic dibit_tick;
  logic switch_now;
  logic rx_busy;
  logic path_busy;

  assign path_busy = rmii_tx_en || rx_busy || rmii_crs_dv;

  rmii_slot_timer #(.SLOW_DIV(SLOW_DIV)) u_timer (
    .clk        (clk),
    .rst_n      (rst_n),
    .fast       (speed_100),
    .restart    (switch_now),
    .dibit_tick (dibit_tick)
  );

  mii_tx_serializer u_tx (
    .clk        (clk),
    .rst_n      (rst_n),
    .dibit_tick (dibit_tick),
    .mii_txd    (mii_txd),
    .mii_tx_en  (mii_tx_en),
    .nibble_stb (mii_tx_stb),
    .rmii_txd   (rmii_txd),
    .rmii_tx_en (rmii_tx_en)
  );

  rmii_rx_gatherer u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .dibit_tick  (dibit_tick),
    .rmii_rxd    (rmii_rxd),
    .rmii_crs_dv (rmii_crs_dv),
    .rmii_rx_er  (rmii_rx_er),
    .in_frame    (rx_busy),
    .out_stb     (mii_rx_stb),
    .mii_rxd     (mii_rxd),
    .mii_rx_dv   (mii_rx_dv),
    .mii_rx_er   (mii_rx_er),
    .mii_crs     (mii_crs)
  );

  rmii_speed_ctrl #(.RESET_FAST(RESET_FAST)) u_speed (
    .clk        (clk),
    .rst_n      (rst_n),
    .speed_req  (speed_100_req),
    .boundary   (mii_tx_stb),
    .busy_now   (path_busy),
    .mac_tx_en  (mii_tx_en),
    .speed_fast (speed_100),
    .switch_now (switch_now)
  );
endmodule

// File: rtl/mii_rmii_bridge_chk.sv
module mii_rmii_bridge_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dibit_tick,
  input logic       rx_busy,
  input logic       speed_100,
  input logic       mii_tx_stb,
  input logic       mii_tx_en,
  input logic [1:0] rmii_txd,
  input logic       rmii_tx_en,
  input logic       mii_rx_stb,
  input logic       mii_rx_dv,
  input logic       mii_rx_er
);
  // R3
  tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dibit_tick |=> $stable({rmii_txd, rmii_tx_en}));

  // R1
  stb_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mii_tx_stb |=> !mii_tx_stb);

  // R9
  speed_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(speed_100) |->
      $past(mii_tx_stb && !mii_tx_en && !rmii_tx_en && !rx_busy));

  // R6
  dv_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mii_rx_dv) |-> mii_rx_stb);

  // R7
  er_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    mii_rx_er |-> mii_rx_dv);
endmodule

bind mii_rmii_bridge mii_rmii_bridge_chk u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .dibit_tick (dibit_tick),
  .rx_busy    (rx_busy),
  .speed_100  (speed_100),
  .mii_tx_stb (mii_tx_stb),
  .mii_tx_en  (mii_tx_en),
  .rmii_txd   (rmii_txd),
  .rmii_tx_en (rmii_tx_en),
  .mii_rx_stb (mii_rx_stb),
  .mii_rx_dv  (mii_rx_dv),
  .mii_rx_er  (mii_rx_er)
);

// File: tb/sim_mii_rmii_bridge.sv
module sim_mii_rmii_bridge;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       speed_100_req = 1'b1;
  logic       speed_100;
  logic       mii_tx_stb;
  logic [3:0] mii_txd = '0;
  logic       mii_tx_en = 1'b0;
  logic [1:0] rmii_txd;
  logic       rmii_tx_en;
  logic [1:0] rmii_rxd = '0;
  logic       rmii_crs_dv = 1'b0;
  logic       rmii_rx_er = 1'b0;
  logic       mii_rx_stb;
  logic [3:0] mii_rxd;
  logic       mii_rx_dv;
  logic       mii_rx_er;
  logic       mii_crs;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = !clk;

  mii_rmii_bridge u0 (
    .clk(clk), .rst_n(rst_n), .speed_100_req(speed_100_req), .speed_100(speed_100),
    .mii_tx_stb(mii_tx_stb), .mii_txd(mii_txd), .mii_tx_en(mii_tx_en),
    .rmii_txd(rmii_txd), .rmii_tx_en(rmii_tx_en), .rmii_rxd(rmii_rxd),
    .rmii_crs_dv(rmii_crs_dv), .rmii_rx_er(rmii_rx_er), .mii_rx_stb(mii_rx_stb),
    .mii_rxd(mii_rxd), .mii_rx_dv(mii_rx_dv), .mii_rx_er(mii_rx_er), .mii_crs(mii_crs)
  );

  task automatic chk(input bit ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", what, act, exp);
    end
  endtask

  // strobe spacing monitor (R1)
  int gap = 0;
  bit seen_stb = 1'b0;
  int gap_bad = 0;
  int gap_last_bad = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      gap++;
      if (mii_tx_stb) begin
        if (seen_stb && gap != 2 && gap != 20) begin
          gap_bad++;
          gap_last_bad = gap;
        end
        gap = 0;
        seen_stb = 1'b1;
      end
    end
  end

  // receive nibble recorder
  logic [3:0] got_n [0:127];
  logic       got_e [0:127];
  int got_cnt = 0;
  always @(negedge clk) begin
    if (rst_n && mii_rx_stb && mii_rx_dv && got_cnt < 128) begin
      got_n[got_cnt] = mii_rxd;
      got_e[got_cnt] = mii_rx_er;
      got_cnt++;
    end
  end

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(rmii_tx_en === 1'b0 && rmii_txd === 2'b00, "R10 tx idle in reset", {rmii_txd, rmii_tx_en}, 0);
    chk(mii_rx_dv === 1'b0 && mii_rx_er === 1'b0 && mii_crs === 1'b0 && mii_rxd === 4'h0,
        "R10 rx idle in reset", {mii_rxd, mii_rx_dv, mii_rx_er, mii_crs}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(speed_100 === 1'b1, "R10 reset speed", speed_100, 1);
  endtask

  // transmit frame of 8 nibbles plus one idle nibble; d = cycles per dibit
  task automatic t_tx(input int d, input bit flip);
    logic [3:0] n;
    logic [1:0] exp_d;
    bit   orig;
    int   bad;
    int   act_v;
    int   exp_v;
    orig = speed_100;
    do @(negedge clk); while (!mii_tx_stb);
    for (int i = 0; i < 9; i++) begin
      n = (i < 8) ? 4'((i * 7 + 3) % 16) : 4'h0;
      mii_txd = n;
      mii_tx_en = (i < 8);
      if (flip && i == 1) speed_100_req = !orig;
      bad = 0; act_v = 0; exp_v = 0;
      for (int k = 1; k <= 2 * d; k++) begin
        @(negedge clk);
        exp_d = (k <= d) ? n[1:0] : n[3:2];
        if (rmii_txd !== exp_d || rmii_tx_en !== (i < 8) || mii_tx_stb !== (k == 2 * d)) begin
          bad++;
          act_v = {mii_tx_stb, rmii_tx_en, rmii_txd};
          exp_v = {(k == 2 * d), (i < 8), exp_d};
        end
      end
      chk(bad == 0, (d == 1) ? "R2 tx nibble 100M" : "R2 R3 tx nibble held 10M", act_v, exp_v);
    end
    mii_txd = 4'h0;
    mii_tx_en = 1'b0;
    if (flip) chk(speed_100 === orig, "R9 speed change deferred during frame", speed_100, orig);
  endtask

  task automatic put(input logic [1:0] dd, input logic c, input logic e, input int d);
    rmii_rxd = dd;
    rmii_crs_dv = c;
    rmii_rx_er = e;
    repeat (d) @(negedge clk);
  endtask

  task automatic t_rx(input int d);
    logic [3:0] exp_n [0:10];
    bit         exp_e [0:10];
    logic [3:0] v;
    int base;
    int bad;
    int act_v;
    int exp_v;
    base = got_cnt;
    exp_n[0] = 4'h5; exp_n[1] = 4'h5; exp_n[2] = 4'hD;
    for (int i = 0; i < 6; i++) exp_n[3 + i] = 4'((i * 5 + 2) % 16);
    exp_n[9] = 4'hA; exp_n[10] = 4'h3;
    for (int i = 0; i < 11; i++) exp_e[i] = (i == 6);
    // idle, including a 01 without carrier (R5)
    put(2'b00, 1'b0, 1'b0, d);
    put(2'b01, 1'b0, 1'b0, d);
    put(2'b00, 1'b0, 1'b0, d);
    // carrier with zero dibits before the preamble
    put(2'b00, 1'b1, 1'b0, d);
    put(2'b00, 1'b1, 1'b0, d);
    for (int i = 0; i < 5; i++) put(2'b01, 1'b1, 1'b0, d);
    put(2'b11, 1'b1, 1'b0, d);
    chk(mii_crs === 1'b1, "R8 carrier reported", mii_crs, 1);
    for (int i = 0; i < 6; i++) begin
      v = exp_n[3 + i];
      put(v[1:0], 1'b1, 1'b0, d);
      put(v[3:2], 1'b1, (i == 3), d);
    end
    // end of frame: carrier low on first dibit, high on second (R6)
    put(2'b10, 1'b0, 1'b0, d);
    put(2'b10, 1'b1, 1'b0, d);
    put(2'b11, 1'b0, 1'b0, d);
    put(2'b00, 1'b1, 1'b0, d);
    put(2'b00, 1'b0, 1'b0, d);
    put(2'b00, 1'b0, 1'b0, d);
    for (int i = 0; i < 4; i++) put(2'b00, 1'b0, 1'b0, d);
    chk(got_cnt - base == 11, "R5 R6 valid nibble count", got_cnt - base, 11);
    bad = 0; act_v = 0; exp_v = 0;
    for (int i = 0; i < 11 && base + i < got_cnt; i++) begin
      if (got_n[base + i] !== exp_n[i]) begin
        bad++; act_v = got_n[base + i]; exp_v = exp_n[i];
      end
    end
    chk(bad == 0, (d == 1) ? "R4 R5 rx nibble order 100M" : "R4 R5 rx nibble order 10M", act_v, exp_v);
    bad = 0; act_v = 0; exp_v = 0;
    for (int i = 0; i < 11 && base + i < got_cnt; i++) begin
      if (got_e[base + i] !== exp_e[i]) begin
        bad++; act_v = i; exp_v = 6;
      end
    end
    chk(bad == 0, "R7 rx error on flagged nibble only", act_v, exp_v);
    chk(mii_rx_dv === 1'b0, "R6 valid dropped after frame", mii_rx_dv, 0);
    chk(mii_crs === 1'b0, "R8 carrier cleared", mii_crs, 0);
  endtask

  initial begin
    t_reset();
    t_tx(1, 1'b0);
    t_rx(1);
    t_tx(1, 1'b1);
    repeat (100) @(negedge clk);
    chk(speed_100 === 1'b0, "R9 slow speed adopted when quiet", speed_100, 0);
    t_tx(10, 1'b0);
    t_rx(10);
    speed_100_req = 1'b1;
    repeat (300) @(negedge clk);
    chk(speed_100 === 1'b1, "R9 fast speed adopted when quiet", speed_100, 1);
    t_tx(1, 1'b0);
    chk(gap_bad == 0, "R1 strobe spacing", gap_last_bad, 2);
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule